// File: doc/BRIEF.md
# Pattern Sequencer Register and Program Loader

This block is the software-facing register slave of a pulse pattern sequencer. A 32-bit word bus with a byte offset, a write strobe and a combinational read path reaches a scratch word, a control/status word, a program address word, four instruction staging words, a flash control word and three read-only constant words. A 128-bit instruction is built from four 32-bit writes. Writing the highest staging word commits all 128 bits to program memory in one write cycle at the current program address. The address then steps by one, so a program is loaded as a flat stream of writes.

The control/status word holds four stored control bits: external clock select, external start enable, slow clock and test mode. It also shows live sequencer state: the run flag, PC, stack pointer and the low bits of the delay counter. A program starts from a software write of the run bit or, when external start is enabled, from a synchronized rising edge of an asynchronous start input. In test mode the 32 pattern outputs show the program address register in place of the sequencer pattern.

Top module: `pgen_ctrl_regs`

## Requirements
- R1: The word at byte offset 0x00 reads back the last value written to it, with all 32 bits preserved.
- R2: The word at 0x04 has bit 0 = run, bit 1 = external clock, bit 2 = external start enable, bit 3 = slow clock and bit 4 = test mode. Bits 1-4 are stored on write and drive `ext_clk_sel`, `ext_start_en`, `slow_clk_sel` and `test_mode` from the next cycle. Bits 5-16 read `seq_pc`, bits 17-24 read `seq_sp` and bits 25-31 read `seq_delay[6:0]`. Writes to bits 5-31 are discarded.
- R3: Bit 0 of 0x04 always reads the live `seq_running` input, whatever was written to it.
- R4: With external start disabled and `seq_running` low, a write to 0x04 with bit 0 set gives a one-cycle `seq_start` pulse in the cycle after the write. The write has no effect if `seq_running` is high.
- R5: With external start already enabled, run-bit writes do not start the program. A rising edge on `ext_start_in` gives a one-cycle `seq_start` three clock edges after it is first sampled, unless `seq_running` is high at that point. `seq_start` is never asserted in a cycle after an edge that saw `seq_running` high.
- R6: The four words at 0x0C, 0x10, 0x14 and 0x18 hold instruction bits 31:0, 63:32, 95:64 and 127:96, and each reads back its last written value.
- R7: A write to 0x18 gives `mem_we` high for exactly the next cycle. `mem_waddr` is the program address before the write, and `mem_wdata` is {written word, word 0x14, word 0x10, word 0x0C}. No other write raises `mem_we`.
- R8: The word at 0x08 reads back the written program address. Each commit adds one to it. `seq_start_pc` always shows its low 12 bits.
- R9: While test mode is set, `pattern_out` equals the program address register. Otherwise it equals `seq_pattern`.
- R10: Offsets 0x1C, 0x24 and 0x28 return the VERSION, SERIAL and HW_ID parameters, and writes to them change nothing. Offsets 0x2C-0x3C read zero.
- R11: The word at 0x20 reads back its written value and drives `flash_ctrl`.
- R12: After reset every stored word is zero, and `seq_start`, `mem_we` and all control outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte offset of the accessed word |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| seq_running | input | 1 | Sequencer is executing |
| seq_pc | input | 12 | Sequencer program counter |
| seq_sp | input | 8 | Sequencer stack pointer |
| seq_delay | input | 32 | Sequencer delay counter |
| seq_pattern | input | 32 | Pattern produced by the sequencer |
| ext_start_in | input | 1 | Asynchronous external start |
| seq_start | output | 1 | One-cycle start request |
| seq_start_pc | output | 12 | Start address for the sequencer |
| ext_clk_sel | output | 1 | External clock select |
| ext_start_en | output | 1 | External start enable |
| slow_clk_sel | output | 1 | Slow clock bit, stored only |
| test_mode | output | 1 | Test mode |
| mem_we | output | 1 | Program memory write enable |
| mem_waddr | output | 12 | Program memory write address |
| mem_wdata | output | 128 | Program memory write data |
| flash_ctrl | output | 32 | Flash control word |
| pattern_out | output | 32 | Pattern outputs |

## Verification
The hardest case to reach is an external start edge that meets a running sequencer, or one that arrives just as software writes the enable bit. The edge first passes through the synchronizer, so its effect shows three edges later. The bench holds `ext_start_in` and `seq_running` through those windows on purpose, and then toggles them at random alongside random bus writes. A second case is a commit that lands right after an address write. Here the memory address must be the newly written one, and the very next commit must use that address plus one.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned INSTR_WORDS = 4;
    localparam int unsigned INSTR_W     = WORD_W * INSTR_WORDS;
    localparam int unsigned SEL_W       = $clog2(INSTR_WORDS);
    localparam int unsigned BUS_AW      = 6;
    localparam int unsigned CTRL_BITS   = 5;

    typedef logic [3:0] reg_idx_t;

    localparam reg_idx_t IDX_SCRATCH = 4'd0;
    localparam reg_idx_t IDX_CSR     = 4'd1;
    localparam reg_idx_t IDX_PADDR   = 4'd2;
    localparam reg_idx_t IDX_IW0     = 4'd3;
    localparam reg_idx_t IDX_IW3     = 4'd6;
    localparam reg_idx_t IDX_VER     = 4'd7;
    localparam reg_idx_t IDX_FLASH   = 4'd8;
    localparam reg_idx_t IDX_SERIAL  = 4'd9;
    localparam reg_idx_t IDX_HWID    = 4'd10;

    typedef struct packed {
        logic test_mode;
        logic slow_clk;
        logic ext_start_en;
        logic ext_clk;
    } ctrl_t;
endpackage

// File: rtl/pgen_start_sync.sv
module pgen_start_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/pgen_instr_stage.sv
module pgen_instr_stage
    import pgen_pkg::*;
#(
    parameter int unsigned PC_W = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [SEL_W-1:0]                     wr_sel,
    input  logic [WORD_W-1:0]                    wr_data,
    input  logic [PC_W-1:0]                      commit_addr,
    output logic [INSTR_WORDS-1:0][WORD_W-1:0]   words_o,
    output logic                                 mem_we,
    output logic [PC_W-1:0]                      mem_waddr,
    output logic [INSTR_W-1:0]                   mem_wdata
);
    typedef struct packed {
        logic [INSTR_WORDS-1:0][WORD_W-1:0] words;
        logic                               we;
        logic [PC_W-1:0]                    waddr;
        logic [INSTR_W-1:0]                 wdata;
    } stage_t;

    stage_t st_d, st_q;
    logic [INSTR_WORDS-1:0][WORD_W-1:0] merged;
    logic commit;

    for (genvar gi = 0; gi < INSTR_WORDS; gi++) begin : g_merge
        assign merged[gi] = (wr_en && wr_sel == SEL_W'(gi)) ? wr_data : st_q.words[gi];
    end

    assign commit = wr_en && (wr_sel == SEL_W'(INSTR_WORDS - 1));

    always_comb begin
        st_d       = st_q;
        st_d.words = merged;
        st_d.we    = commit;
        if (commit) begin
            st_d.waddr = commit_addr;
            st_d.wdata = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words_o   = st_q.words;
    assign mem_we    = st_q.we;
    assign mem_waddr = st_q.waddr;
    assign mem_wdata = st_q.wdata;
endmodule

// File: rtl/pgen_rd_mux.sv
module pgen_rd_mux
    import pgen_pkg::*;
#(
    parameter logic [WORD_W-1:0] VERSION = 32'h0,
    parameter logic [WORD_W-1:0] SERIAL  = 32'h0,
    parameter logic [WORD_W-1:0] HW_ID   = 32'h0
) (
    input  reg_idx_t                             rd_idx,
    input  logic [WORD_W-1:0]                    scratch,
    input  logic [WORD_W-1:0]                    csr_word,
    input  logic [WORD_W-1:0]                    paddr,
    input  logic [INSTR_WORDS-1:0][WORD_W-1:0]   words,
    input  logic [WORD_W-1:0]                    flash,
    output logic [WORD_W-1:0]                    rdata
);
    reg_idx_t rel;
    assign rel = rd_idx - IDX_IW0;

    always_comb begin
        rdata = '0;
        if (rd_idx >= IDX_IW0 && rd_idx <= IDX_IW3) begin
            rdata = words[rel[SEL_W-1:0]];
        end else begin
            case (rd_idx)
                IDX_SCRATCH: rdata = scratch;
                IDX_CSR:     rdata = csr_word;
                IDX_PADDR:   rdata = paddr;
                IDX_VER:     rdata = VERSION;
                IDX_FLASH:   rdata = flash;
                IDX_SERIAL:  rdata = SERIAL;
                IDX_HWID:    rdata = HW_ID;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pgen_ctrl_regs.sv
module pgen_ctrl_regs
    import pgen_pkg::*;
#(
    parameter int unsigned       PC_W        = 12,
    parameter int unsigned       SP_W        = 8,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [31:0]       VERSION     = 32'h4CD8_7A00,
    parameter logic [31:0]       SERIAL      = 32'h0000_0107,
    parameter logic [31:0]       HW_ID       = 32'h5047_3332
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [5:0]         bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               seq_running,
    input  logic [PC_W-1:0]    seq_pc,
    input  logic [SP_W-1:0]    seq_sp,
    input  logic [31:0]        seq_delay,
    input  logic [31:0]        seq_pattern,
    input  logic               ext_start_in,
    output logic               seq_start,
    output logic [PC_W-1:0]    seq_start_pc,
    output logic               ext_clk_sel,
    output logic               ext_start_en,
    output logic               slow_clk_sel,
    output logic               test_mode,
    output logic               mem_we,
    output logic [PC_W-1:0]    mem_waddr,
    output logic [127:0]       mem_wdata,
    output logic [31:0]        flash_ctrl,
    output logic [31:0]        pattern_out
);
    localparam int unsigned STAT_W   = WORD_W - CTRL_BITS;
    localparam int unsigned DLY_SHOW = STAT_W - PC_W - SP_W;

    typedef struct packed {
        logic [WORD_W-1:0] scratch;
        ctrl_t             ctrl;
        logic [WORD_W-1:0] paddr;
        logic [WORD_W-1:0] flash;
        logic              start;
    } regs_t;

    regs_t    st_d, st_q;
    reg_idx_t idx;
    reg_idx_t instr_rel;
    logic     instr_wr;
    logic     commit;
    logic     ext_rise;
    logic     sw_start;
    logic     hw_start;
    logic [WORD_W-1:0] csr_word;
    logic [INSTR_WORDS-1:0][WORD_W-1:0] staged;

    assign idx       = bus_addr[BUS_AW-1:2];
    assign instr_rel = idx - IDX_IW0;
    assign instr_wr  = bus_wr && (idx >= IDX_IW0) && (idx <= IDX_IW3);
    assign commit    = bus_wr && (idx == IDX_IW3);

    pgen_start_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ext_start_in),
        .rise_o  (ext_rise)
    );

    assign sw_start = bus_wr && (idx == IDX_CSR) && bus_wdata[0]
                      && !st_q.ctrl.ext_start_en && !seq_running;
    assign hw_start = ext_rise && st_q.ctrl.ext_start_en && !seq_running;

    always_comb begin
        st_d       = st_q;
        st_d.start = sw_start || hw_start;
        if (bus_wr) begin
            case (idx)
                IDX_SCRATCH: st_d.scratch = bus_wdata;
                IDX_CSR:     st_d.ctrl    = ctrl_t'(bus_wdata[CTRL_BITS-1:1]);
                IDX_PADDR:   st_d.paddr   = bus_wdata;
                IDX_FLASH:   st_d.flash   = bus_wdata;
                default:     ;
            endcase
        end
        if (commit) st_d.paddr = st_q.paddr + 32'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pgen_instr_stage #(
        .PC_W(PC_W)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (instr_wr),
        .wr_sel     (instr_rel[SEL_W-1:0]),
        .wr_data    (bus_wdata),
        .commit_addr(st_q.paddr[PC_W-1:0]),
        .words_o    (staged),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata)
    );

    assign csr_word = {seq_delay[DLY_SHOW-1:0], seq_sp, seq_pc, st_q.ctrl, seq_running};

    pgen_rd_mux #(
        .VERSION(VERSION),
        .SERIAL (SERIAL),
        .HW_ID  (HW_ID)
    ) u_rd (
        .rd_idx  (idx),
        .scratch (st_q.scratch),
        .csr_word(csr_word),
        .paddr   (st_q.paddr),
        .words   (staged),
        .flash   (st_q.flash),
        .rdata   (bus_rdata)
    );

    assign seq_start    = st_q.start;
    assign seq_start_pc = st_q.paddr[PC_W-1:0];
    assign ext_clk_sel  = st_q.ctrl.ext_clk;
    assign ext_start_en = st_q.ctrl.ext_start_en;
    assign slow_clk_sel = st_q.ctrl.slow_clk;
    assign test_mode    = st_q.ctrl.test_mode;
    assign flash_ctrl   = st_q.flash;
    assign pattern_out  = st_q.ctrl.test_mode ? st_q.paddr : seq_pattern;
endmodule

// File: rtl/pgen_ctrl_regs_chk.sv
module pgen_ctrl_regs_chk #(
    parameter int unsigned PC_W    = 12,
    parameter logic [31:0] VERSION = 32'h0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [5:0]      bus_addr,
    input logic            bus_wr,
    input logic [31:0]     bus_rdata,
    input logic            seq_running,
    input logic            seq_start,
    input logic [PC_W-1:0] seq_start_pc,
    input logic            test_mode,
    input logic            mem_we,
    input logic [PC_W-1:0] mem_waddr,
    input logic [31:0]     pattern_out
);
    a_r7_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[5:2] == 4'd6) |=> mem_we);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[5:2] == 4'd6) |=> !mem_we);

    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> seq_start_pc == PC_W'(mem_waddr + 1'b1));

    a_r5_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> !$past(seq_running));

    a_r9_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> pattern_out[PC_W-1:0] == seq_start_pc);

    a_r10_version: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[5:2] == 4'd7) |-> bus_rdata == VERSION);

    a_r3_run_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[5:2] == 4'd1) |-> bus_rdata[0] == seq_running);
endmodule

bind pgen_ctrl_regs pgen_ctrl_regs_chk #(
    .PC_W   (PC_W),
    .VERSION(VERSION)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .seq_running (seq_running),
    .seq_start   (seq_start),
    .seq_start_pc(seq_start_pc),
    .test_mode   (test_mode),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .pattern_out (pattern_out)
);

// File: tb/pgen_ctrl_regs_test.sv
`timescale 1ns/1ps
module pgen_ctrl_regs_test;
    localparam logic [31:0] VER = 32'h4CD8_7A00;
    localparam logic [31:0] SER = 32'h0000_0107;
    localparam logic [31:0] HWI = 32'h5047_3332;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic seq_running = 1'b0;
    logic [11:0] seq_pc = '0;
    logic [7:0] seq_sp = '0;
    logic [31:0] seq_delay = '0, seq_pattern = '0;
    logic ext_start_in = 1'b0;
    logic seq_start, ext_clk_sel, ext_start_en, slow_clk_sel, test_mode, mem_we;
    logic [11:0] seq_start_pc, mem_waddr;
    logic [127:0] mem_wdata;
    logic [31:0] flash_ctrl, pattern_out;

    int checks = 0, fails = 0;
    bit live = 1'b0;

    always #5 clk = ~clk;

    pgen_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_running(seq_running),
        .seq_pc(seq_pc), .seq_sp(seq_sp), .seq_delay(seq_delay),
        .seq_pattern(seq_pattern), .ext_start_in(ext_start_in),
        .seq_start(seq_start), .seq_start_pc(seq_start_pc),
        .ext_clk_sel(ext_clk_sel), .ext_start_en(ext_start_en),
        .slow_clk_sel(slow_clk_sel), .test_mode(test_mode), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .flash_ctrl(flash_ctrl),
        .pattern_out(pattern_out)
    );

    // behavioural reference state
    logic [31:0] m_scratch = '0, m_paddr = '0, m_flash = '0;
    logic [3:0]  m_ctrl = '0; // {test, slow, ext start, ext clk}
    logic [31:0] m_w [4] = '{default: '0};
    logic        m_we = 1'b0, m_start = 1'b0;
    logic [11:0] m_waddr = '0;
    logic [127:0] m_wdata = '0;
    logic [2:0]  m_hist = '0; // last three samples of ext_start_in, newest in bit 0

    always @(posedge clk) begin
        if (!rst_n) begin
            m_scratch <= '0; m_paddr <= '0; m_flash <= '0; m_ctrl <= '0;
            m_w <= '{default: '0}; m_we <= 1'b0; m_start <= 1'b0;
            m_waddr <= '0; m_wdata <= '0; m_hist <= '0;
        end else begin
            automatic int i = int'(bus_addr[5:2]);
            automatic logic edge_seen = m_hist[1] && !m_hist[2];
            m_hist  <= {m_hist[1:0], ext_start_in};
            m_we    <= 1'b0;
            m_start <= (!seq_running && m_ctrl[1] && edge_seen) ||
                       (!seq_running && !m_ctrl[1] && bus_wr && i == 1 && bus_wdata[0]);
            if (bus_wr) begin
                if (i == 0) m_scratch <= bus_wdata;
                if (i == 1) m_ctrl <= bus_wdata[4:1];
                if (i == 2) m_paddr <= bus_wdata;
                if (i == 8) m_flash <= bus_wdata;
                if (i >= 3 && i <= 6) m_w[i-3] <= bus_wdata;
                if (i == 6) begin
                    m_we    <= 1'b1;
                    m_waddr <= m_paddr[11:0];
                    m_wdata <= {bus_wdata, m_w[2], m_w[1], m_w[0]};
                    m_paddr <= m_paddr + 32'd1;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(input int i);
        case (i)
            0: return m_scratch;
            1: return {seq_delay[6:0], seq_sp, seq_pc, m_ctrl, seq_running};
            2: return m_paddr;
            3, 4, 5, 6: return m_w[i-3];
            7: return VER;
            8: return m_flash;
            9: return SER;
            10: return HWI;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input int i);
        case (i)
            0: return "R1";
            1: return "R2 R3";
            2: return "R8";
            3, 4, 5, 6: return "R6";
            8: return "R11";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (live) begin
            chk(rd_tag(int'(bus_addr[5:2])), 128'(bus_rdata), 128'(exp_rd(int'(bus_addr[5:2]))));
            chk("R4 R5 seq_start", 128'(seq_start), 128'(m_start));
            chk("R7 mem_we", 128'(mem_we), 128'(m_we));
            if (m_we) begin
                chk("R7 mem_waddr", 128'(mem_waddr), 128'(m_waddr));
                chk("R7 mem_wdata", mem_wdata, m_wdata);
            end
            chk("R8 seq_start_pc", 128'(seq_start_pc), 128'(m_paddr[11:0]));
            chk("R2 ctrl outputs", 128'({test_mode, slow_clk_sel, ext_start_en, ext_clk_sel}), 128'(m_ctrl));
            chk("R9 pattern_out", 128'(pattern_out), 128'(m_ctrl[3] ? m_paddr : seq_pattern));
            chk("R11 flash_ctrl", 128'(flash_ctrl), 128'(m_flash));
        end
    end

    task automatic wr(input int i, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(i * 4); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int i);
        @(negedge clk);
        bus_addr = 6'(i * 4); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(posedge clk); live = 1'b1;
        @(posedge clk); @(negedge clk);
        // R12 reset state
        chk("R12 reset outputs", 128'({seq_start, mem_we, ext_clk_sel, ext_start_en, slow_clk_sel, test_mode}), 128'(0));
        chk("R12 reset flash", 128'(flash_ctrl), 128'(0));
        rst_n = 1'b1;
        rd(0); rd(2); rd(6);
        // R1 scratch patterns
        wr(0, 32'hA5A5_5A5A); rd(0);
        wr(0, 32'hFFFF_FFFF); rd(0);
        wr(0, 32'h0); rd(0);
        // R6 R7 R8 instruction load
        wr(2, 32'h10);
        wr(3, 32'h1111_0001); wr(4, 32'h2222_0002); wr(5, 32'h3333_0003); wr(6, 32'h0004_0001);
        rd(3); rd(4); rd(5); rd(6); rd(2);
        wr(3, 32'hDEAD_BEEF); wr(6, 32'h0060_0000); rd(2);
        wr(2, 32'hFFF); wr(6, 32'h1); rd(2);
        wr(6, 32'h2); rd(2);
        // R2 R3 status and control
        seq_pc = 12'hABC; seq_sp = 8'h5A; seq_delay = 32'h0000_007F; seq_running = 1'b1;
        wr(1, 32'hFFFF_FFE0 | 32'h1E); rd(1);
        seq_running = 1'b0; rd(1);
        wr(1, 32'h0); rd(1);
        // R4 software start
        wr(1, 32'h1); idle(2);
        seq_running = 1'b1; wr(1, 32'h1); idle(2);
        seq_running = 1'b0;
        // R9 test mode
        seq_pattern = 32'hCAFE_F00D; wr(2, 32'h1234_5678); wr(1, 32'h10); rd(1); wr(1, 32'h0); rd(1);
        // R5 external start
        wr(1, 32'h4); wr(1, 32'h5); idle(3);
        @(negedge clk) ext_start_in = 1'b1; idle(6);
        @(negedge clk) ext_start_in = 1'b0; idle(4);
        seq_running = 1'b1;
        @(negedge clk) ext_start_in = 1'b1; idle(6);
        @(negedge clk) ext_start_in = 1'b0; seq_running = 1'b0; idle(4);
        wr(1, 32'h0);
        // R10 constants and unmapped offsets
        for (int k = 7; k < 16; k++) begin
            if (k != 8) wr(k, 32'h5555_AAAA);
            rd(k);
        end
        // R11 flash word
        wr(8, 32'h8000_0003); rd(8);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            bus_addr     = 6'($urandom_range(0, 63));
            bus_wr       = ($urandom_range(0, 2) == 0);
            bus_wdata    = $urandom;
            seq_running  = ($urandom_range(0, 3) == 0);
            seq_pc       = 12'($urandom); seq_sp = 8'($urandom);
            seq_delay    = $urandom; seq_pattern = $urandom;
            if ($urandom_range(0, 4) == 0) ext_start_in = ~ext_start_in;
        end
        @(negedge clk) bus_wr = 1'b0;
        idle(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule